// File: doc/BRIEF.md
# SPI Status Flags and Interrupt Logic

This block holds the status and control state of a serial peripheral port. It sits between a CPU register bus and the serial shift engine. The engine reports two kinds of event: a received byte has finished shifting in, and the transmit holding register has handed a byte to the shifter. The block keeps four sticky flags: receive-full, overflow, mode-fault and transmit-empty. It also keeps a small control register and drives three interrupt requests. When a received byte finishes, the block decides whether the byte may enter the receive register. If it may not, the engine is told to discard it, so the older byte is kept.

Software clears receive-full, overflow and mode-fault with a two-step sequence. First a status read must see the flag set, which arms that flag's clear. The clear then completes on a receive data read (receive-full and overflow) or on a control write (mode-fault). A data read or control write that no armed status read came before it changes nothing. If a flag's set event falls in the same cycle as its completing clear step, the set wins. The mode-fault rule depends on whether the port is master or slave.

Top module: `spi_flag_ctl`

## Requirements
- R1: After reset the status byte is 8'h08 (only transmit-empty set), the control register is zero, and rx_irq, tx_irq, err_irq, rx_load and ovf_drop are all 0.
- R2: The status byte, bit 7 down to bit 0, is {receive-full, error-irq-enable, overflow, mode-fault, transmit-empty, mode-fault-enable, rate[1], rate[0]}. A ctl_wr loads ctl_wdata with rate in [5:4], mode-fault-enable in [3], error-irq-enable in [2], tx-irq-enable in [1] and rx-irq-enable in [0].
- R3: When rx_done arrives and the receive register is free, rx_load is high in that cycle and receive-full is 1 from the next cycle. rx_irq equals receive-full AND rx-irq-enable.
- R4: When rx_done arrives while receive-full is 1 and no clear completes in that cycle, ovf_drop is high, rx_load is low, overflow sets and receive-full stays 1.
- R5: Receive-full and overflow clear only on a data_rd that follows a stat_rd which saw them set. A data_rd with no such armed read leaves both unchanged.
- R6: If rx_done falls in the same cycle as a completing data_rd, the byte loads (rx_load high, ovf_drop low) and receive-full stays 1.
- R7: In slave mode (master=0) with mode-fault-enable set, mode-fault sets when ss_n is high while xfer_active is high. With xfer_active low, ss_n high sets nothing.
- R8: In master mode with mode-fault-enable set, mode-fault sets whenever ss_n is low. With mode-fault-enable clear, mode-fault never sets.
- R9: Mode-fault clears only on a ctl_wr that follows a stat_rd which saw it set. An unarmed ctl_wr leaves it unchanged.
- R10: Transmit-empty sets on tx_move and clears on data_wr, and tx_move wins when both come in one cycle. tx_irq equals transmit-empty AND tx-irq-enable.
- R11: err_irq equals error-irq-enable AND (overflow OR mode-fault).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | Engine: a received byte finished shifting |
| tx_move | input | 1 | Engine: transmit byte handed to the shifter |
| ss_n | input | 1 | Slave-select pin level |
| master | input | 1 | 1 = master mode, 0 = slave mode |
| xfer_active | input | 1 | A transfer is in progress |
| stat_rd | input | 1 | CPU reads the status byte |
| data_rd | input | 1 | CPU reads the receive data register |
| data_wr | input | 1 | CPU writes the transmit data register |
| ctl_wr | input | 1 | CPU writes the control register |
| ctl_wdata | input | 6 | Control write data (layout in R2) |
| status | output | 8 | Readable status byte (layout in R2) |
| rx_irq | output | 1 | Receive-full interrupt request |
| tx_irq | output | 1 | Transmit-empty interrupt request |
| err_irq | output | 1 | Overflow / mode-fault interrupt request |
| rx_load | output | 1 | Engine: store this byte in the receive register |
| ovf_drop | output | 1 | Engine: discard this byte |

## Verification
The bound checker watches these rules on every cycle:
- rx_load and ovf_drop never rise together.
- A load sets receive-full, and a drop sets overflow.
- A flag whose clear is not armed cannot fall.
- The master-mode fault rule holds.
- tx_move always leaves transmit-empty set.
- err_irq follows its enable.

Some behaviour only the directed scenarios can show: the exact status encodings after each sequence, set-wins in the same cycle as a completing read, the slave-mode busy qualification, and clears that complete after a correct two-step access.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int RATE_W = 2;
  localparam int STAT_W = 8;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              modf_en;
    logic              err_ie;
    logic              tx_ie;
    logic              rx_ie;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // Status byte assembly; bit order is decoded by software.
  function automatic logic [STAT_W-1:0] pack_status(
    input logic rxf, input logic ovf, input logic modf, input logic txe, input ctl_t c);
    return {rxf, c.err_ie, ovf, modf, txe, c.modf_en, c.rate};
  endfunction

  // Slave-select fault condition for the current mode.
  function automatic logic modf_cond(
    input logic is_master, input logic en, input logic ss_level, input logic busy);
    if (!en) return 1'b0;
    if (is_master) return ~ss_level;
    return ss_level & busy;
  endfunction
endpackage

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic peek_i,
  input  logic finish_i,
  output logic q_o,
  output logic arm_o,
  output logic clr_o
);
  logic q_r, arm_r;

  assign clr_o = finish_i & arm_r;
  assign q_o   = q_r;
  assign arm_o = arm_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r   <= RST_VAL;
      arm_r <= 1'b0;
    end else begin
      if (set_i)      q_r <= 1'b1;
      else if (clr_o) q_r <= 1'b0;
      if (finish_i)    arm_r <= 1'b0;
      else if (peek_i) arm_r <= q_r;
    end
  end
endmodule

// File: rtl/spi_flag_ctl.sv
module spi_flag_ctl
  import spi_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic              tx_move,
  input  logic              ss_n,
  input  logic              master,
  input  logic              xfer_active,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [STAT_W-1:0] status,
  output logic              rx_irq,
  output logic              tx_irq,
  output logic              err_irq,
  output logic              rx_load,
  output logic              ovf_drop
);
  ctl_t ctl_q;
  logic rx_full, ovf, modf, tx_empty;
  logic rx_arm, ovf_arm, modf_arm;
  logic rx_clr, ovf_clr, modf_clr;
  logic rx_free, modf_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_t'(ctl_wdata);
  end

  // Receive register is free if empty, or emptied by this cycle's completing read.
  assign rx_free  = ~rx_full | rx_clr;
  assign rx_load  = rx_done & rx_free;
  assign ovf_drop = rx_done & ~rx_free;
  assign modf_hit = modf_cond(master, ctl_q.modf_en, ss_n, xfer_active);

  spi_sticky_flag #(.RST_VAL(1'b0)) u_rxf (
    .clk(clk), .rst_n(rst_n), .set_i(rx_load), .peek_i(stat_rd), .finish_i(data_rd),
    .q_o(rx_full), .arm_o(rx_arm), .clr_o(rx_clr));

  spi_sticky_flag #(.RST_VAL(1'b0)) u_ovf (
    .clk(clk), .rst_n(rst_n), .set_i(ovf_drop), .peek_i(stat_rd), .finish_i(data_rd),
    .q_o(ovf), .arm_o(ovf_arm), .clr_o(ovf_clr));

  spi_sticky_flag #(.RST_VAL(1'b0)) u_modf (
    .clk(clk), .rst_n(rst_n), .set_i(modf_hit), .peek_i(stat_rd), .finish_i(ctl_wr),
    .q_o(modf), .arm_o(modf_arm), .clr_o(modf_clr));

  always_ff @(posedge clk) begin
    if (!rst_n)       tx_empty <= 1'b1;
    else if (tx_move) tx_empty <= 1'b1;
    else if (data_wr) tx_empty <= 1'b0;
  end

  assign status  = pack_status(rx_full, ovf, modf, tx_empty, ctl_q);
  assign rx_irq  = rx_full & ctl_q.rx_ie;
  assign tx_irq  = tx_empty & ctl_q.tx_ie;
  assign err_irq = ctl_q.err_ie & (ovf | modf);
endmodule

// File: rtl/spi_flag_ctl_chk.sv
module spi_flag_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_done,
  input logic       tx_move,
  input logic       ss_n,
  input logic       master,
  input logic [7:0] status,
  input logic       err_irq,
  input logic       rx_load,
  input logic       ovf_drop,
  input logic       rx_arm,
  input logic       ovf_arm,
  input logic       modf_arm
);
  logic rxf_s, eie_s, ovf_s, modf_s, txe_s, men_s;
  assign rxf_s  = status[7];
  assign eie_s  = status[6];
  assign ovf_s  = status[5];
  assign modf_s = status[4];
  assign txe_s  = status[3];
  assign men_s  = status[2];

  // R4
  load_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_load && ovf_drop));
  // R4
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_drop |=> ovf_s);
  // R3
  load_sets_rxf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rxf_s) |-> rx_load);
  // R3
  rxf_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> rxf_s);
  // R5
  rxf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf_s && !rx_arm) |=> rxf_s);
  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_s && !ovf_arm) |=> ovf_s);
  // R8
  master_modf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && men_s && !ss_n) |=> modf_s);
  // R9
  modf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modf_s && !modf_arm) |=> modf_s);
  // R10
  tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_move |=> txe_s);
  // R11
  err_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eie_s |-> !err_irq);
  // R11
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eie_s && (ovf_s || modf_s)) |-> err_irq);
endmodule

bind spi_flag_ctl spi_flag_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .tx_move(tx_move), .ss_n(ss_n),
  .master(master), .status(status), .err_irq(err_irq), .rx_load(rx_load),
  .ovf_drop(ovf_drop), .rx_arm(rx_arm), .ovf_arm(ovf_arm), .modf_arm(modf_arm));

// File: tb/tb_spi_flag_ctl.sv
module tb_spi_flag_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_done = 0, tx_move = 0, ss_n = 1, master = 0, xfer_active = 0;
  logic stat_rd = 0, data_rd = 0, data_wr = 0, ctl_wr = 0;
  logic [5:0] ctl_wdata = '0;
  logic [7:0] status;
  logic rx_irq, tx_irq, err_irq, rx_load, ovf_drop;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_flag_ctl dut (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .tx_move(tx_move), .ss_n(ss_n),
    .master(master), .xfer_active(xfer_active), .stat_rd(stat_rd), .data_rd(data_rd),
    .data_wr(data_wr), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .status(status),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .err_irq(err_irq), .rx_load(rx_load),
    .ovf_drop(ovf_drop));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    rx_done = 0; tx_move = 0; stat_rd = 0; data_rd = 0; data_wr = 0; ctl_wr = 0;
  endtask

  task automatic wr_ctl(input logic [5:0] v);
    ctl_wdata = v; ctl_wr = 1; tick();
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h08);
    chk("R1 irqs", {5'd0, rx_irq, tx_irq, err_irq}, 8'h00);
    chk("R1 engine", {6'd0, rx_load, ovf_drop}, 8'h00);
  endtask

  task automatic t_ctl();
    wr_ctl(6'b10_0_1_1_1);
    chk("R2 layout", status, 8'h4A);
    chk("R10 tx_irq", {7'd0, tx_irq}, 8'h01);
  endtask

  task automatic t_rx_arm();
    rx_done = 1; #1;
    chk("R3 rx_load", {6'd0, rx_load, ovf_drop}, 8'h02);
    tick();
    chk("R3 rx_full", status, 8'hCA);
    chk("R3 rx_irq", {7'd0, rx_irq}, 8'h01);
    data_rd = 1; tick();
    chk("R5 unarmed read", status, 8'hCA);
    stat_rd = 1; tick();
    data_rd = 1; tick();
    chk("R5 armed clear", status, 8'h4A);
    chk("R3 rx_irq off", {7'd0, rx_irq}, 8'h00);
  endtask

  task automatic t_ovf();
    rx_done = 1; tick();
    rx_done = 1; #1;
    chk("R4 drop", {6'd0, rx_load, ovf_drop}, 8'h01);
    tick();
    chk("R4 ovf set", status, 8'hEA);
    chk("R11 err_irq", {7'd0, err_irq}, 8'h01);
    stat_rd = 1; tick();
    data_rd = 1; tick();
    chk("R5 ovf clear", status, 8'h4A);
    chk("R11 err_irq off", {7'd0, err_irq}, 8'h00);
  endtask

  task automatic t_setwins();
    rx_done = 1; tick();
    stat_rd = 1; tick();
    data_rd = 1; rx_done = 1; #1;
    chk("R6 load on clear", {6'd0, rx_load, ovf_drop}, 8'h02);
    tick();
    chk("R6 set wins", status, 8'hCA);
    stat_rd = 1; tick();
    data_rd = 1; tick();
    chk("R6 cleanup", status, 8'h4A);
  endtask

  task automatic t_err_gate();
    wr_ctl(6'b10_0_0_1_1);
    rx_done = 1; tick();
    rx_done = 1; tick();
    chk("R11 status", status, 8'hAA);
    chk("R11 gated", {7'd0, err_irq}, 8'h00);
    stat_rd = 1; tick();
    data_rd = 1; tick();
    chk("R5 clear", status, 8'h0A);
  endtask

  task automatic t_modf_slave();
    wr_ctl(6'b10_1_1_1_1);
    master = 0; ss_n = 1; xfer_active = 0; tick();
    chk("R7 idle no fault", status, 8'h4E);
    xfer_active = 1; tick();
    xfer_active = 0; tick();
    chk("R7 slave fault", status, 8'h5E);
    chk("R11 modf irq", {7'd0, err_irq}, 8'h01);
    wr_ctl(6'b10_1_1_1_1);
    chk("R9 unarmed write", status, 8'h5E);
    stat_rd = 1; tick();
    wr_ctl(6'b10_1_1_1_1);
    chk("R9 armed clear", status, 8'h4E);
  endtask

  task automatic t_modf_master();
    master = 1; ss_n = 1; tick();
    chk("R8 ss high", status, 8'h4E);
    ss_n = 0; tick();
    ss_n = 1; tick();
    chk("R8 master fault", status, 8'h5E);
    stat_rd = 1; tick();
    wr_ctl(6'b10_0_1_1_1);
    chk("R9 clear", status, 8'h4A);
    ss_n = 0; tick(); tick();
    chk("R8 disabled", status, 8'h4A);
    ss_n = 1; master = 0; tick();
  endtask

  task automatic t_tx();
    data_wr = 1; tick();
    chk("R10 cleared", status, 8'h42);
    chk("R10 tx_irq off", {7'd0, tx_irq}, 8'h00);
    tx_move = 1; tick();
    chk("R10 set", status, 8'h4A);
    data_wr = 1; tx_move = 1; tick();
    chk("R10 set wins", status, 8'h4A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl();
    t_rx_arm();
    t_ovf();
    t_setwins();
    t_err_gate();
    t_modf_slave();
    t_modf_master();
    t_tx();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule